// File: doc/BRIEF.md
# Five-Level Address Translation Walker

This block turns a 49-bit virtual address into a physical address. It walks a tree of translation tables held in memory. The tree has four directory levels and then one leaf level. A requester gives it the base of the top-level table and the virtual address on a valid/ready request port. The walker then reads one 64-bit entry per level through a memory-read request/response port. It decodes each entry and either goes down to the next table or stops. It stops at a leaf, which gives a physical address and the page attribute flags. It also stops at an entry whose target code is zero, which reports a fault together with the level where the walk ended.

Each level takes its own slice of the virtual address, and the slices are not all the same width. The entries at level 3 are 16 bytes wide, while the entries at every other level are 8 bytes wide, so the distance between neighbouring entries depends on the level. For a 16-byte entry the walker fetches and decodes only the low 8 bytes. Only one walk is handled at a time.

Back-pressure works the same way on all three handshakes. A word moves only on a clock edge where both valid and ready are high. A side that raises valid keeps valid and its data unchanged until the handshake completes. Once the walker has accepted a request, it holds `req_ready` low until its result has been taken.

Top module: `tree_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. `req_ready` falls in the cycle after a request handshake. It stays low until the response handshake, and it is 1 again in the cycle right after that handshake.
- R2: The table index at each level is a slice of the virtual address: level 0 uses bits 48:47, level 1 uses bits 46:38, level 2 uses bits 37:29, level 3 uses bits 28:21 and level 4 uses bits 20:12. The first read goes to `req_root` plus the level-0 index times 8.
- R3: The entry address is the table base plus the index times the entry size. The entry size is 16 bytes at level 3 and 8 bytes at levels 0, 1, 2 and 4.
- R4: The base of the next table or page is bits 31:8 of the entry shifted left by 12. Entry bits 63:32 have no effect.
- R5: If an entry's bits 2:0 are 000, the walk ends with `rsp_fault`=1, `rsp_level` set to the level of that entry (0 to 4), `rsp_pa`=0 and all flags 0. No further read is issued for that walk.
- R6: If an entry has bit 0 set, the walk ends at that level. At level 4, any nonzero bits 2:0 end the walk. The result is `rsp_fault`=0, `rsp_level` set to that level, and `rsp_pa` = (entry bits 31:8 shifted left by 12) OR virtual address bits 11:0.
- R7: On a leaf, `rsp_aperture` is entry bits 2:1, `rsp_volatile` is bit 3, `rsp_encrypted` is bit 4 and `rsp_privileged` is bit 5.
- R8: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. At most one read is outstanding, and `mem_rsp_ready` is high only while a read is awaited.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, all response fields stay unchanged.
- R10: Each level costs exactly one 64-bit read. A walk that ends at level L issues exactly L+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_root | input | 36 | Byte address of the level-0 table |
| req_va | input | 49 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaiting read data |
| mem_rsp_data | input | 64 | Entry word (low 8 bytes of the entry) |
| rsp_valid | output | 1 | Walk result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_level | output | 3 | Level where the walk ended |
| rsp_pa | output | 36 | Physical address (0 on fault) |
| rsp_aperture | output | 2 | Leaf aperture select |
| rsp_volatile | output | 1 | Leaf volatile flag |
| rsp_encrypted | output | 1 | Leaf encrypted flag |
| rsp_privileged | output | 1 | Leaf privileged flag |

## Verification
The assertions assume a well-behaved memory. It answers every accepted read with exactly one response word. It raises `mem_rsp_valid` only after a read has been accepted, and it holds that word until `mem_rsp_ready` takes it. The assertions also assume the requester holds `rsp_ready` independently of the walker's internal state. The bench's memory responder keeps at most one pending word. It presents that word only after a read handshake, with a random delay, and drops it on the response handshake. The requester raises `req_valid` only while the bench's own model considers the walker idle.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned LEVELS     = 5;
  localparam int unsigned LVL_W      = 3;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned FIELD_LSB  = 8;
  localparam int unsigned FIELD_W    = 24;
  localparam int unsigned ATTR_W     = 6;

  typedef enum logic [1:0] {
    ENT_BAD  = 2'd0,
    ENT_DIR  = 2'd1,
    ENT_LEAF = 2'd2
  } ent_kind_e;

  typedef struct packed {
    logic [1:0] aper;
    logic       vol;
    logic       enc;
    logic       priv;
  } leaf_flags_t;

  // Lowest virtual-address bit used as index at a level.
  function automatic int unsigned idx_lsb(int unsigned lvl);
    case (lvl)
      0:       return 47;
      1:       return 38;
      2:       return 29;
      3:       return 21;
      default: return 12;
    endcase
  endfunction

  // Index width in bits at a level.
  function automatic int unsigned idx_width(int unsigned lvl);
    case (lvl)
      0:       return 2;
      3:       return 8;
      default: return 9;
    endcase
  endfunction

  // log2 of entry size in bytes at a level.
  function automatic int unsigned stride_log2(int unsigned lvl);
    return (lvl == 3) ? 4 : 3;
  endfunction
endpackage

// File: rtl/tw_index_sel.sv
module tw_index_sel
  import tw_pkg::*;
#(
  parameter int unsigned VA_W = 49,
  parameter int unsigned PA_W = 36
) (
  input  logic [VA_W-1:PAGE_SHIFT] vpn,
  input  logic [PA_W-1:0]          base,
  input  logic [LVL_W-1:0]         level,
  output logic [PA_W-1:0]          ent_addr
);
  logic [LEVELS-1:0][PA_W-1:0] cand;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int unsigned LSB = idx_lsb(g);
    localparam int unsigned W   = idx_width(g);
    localparam int unsigned SH  = stride_log2(g);
    logic [W-1:0]    idx;
    logic [PA_W-1:0] offs;
    assign idx     = vpn[LSB+W-1:LSB];
    assign offs    = {{(PA_W-W){1'b0}}, idx} << SH;
    assign cand[g] = base + offs;
  end

  always_comb begin
    ent_addr = cand[0];
    for (int i = 1; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) ent_addr = cand[i];
    end
  end
endmodule

// File: rtl/tw_entry_decode.sv
module tw_entry_decode
  import tw_pkg::*;
#(
  parameter int unsigned PA_W = 36
) (
  input  logic [FIELD_W-1:0] addr_field,
  input  logic [ATTR_W-1:0]  attr,
  input  logic               last_lvl,
  output ent_kind_e          kind,
  output logic [PA_W-1:0]    next_base,
  output leaf_flags_t        flags
);
  logic [2:0] tgt;
  assign tgt       = attr[2:0];
  assign next_base = PA_W'({addr_field, {PAGE_SHIFT{1'b0}}});

  always_comb begin
    if (tgt == 3'b000)             kind = ENT_BAD;
    else if (attr[0] || last_lvl)  kind = ENT_LEAF;
    else                           kind = ENT_DIR;
  end

  assign flags.aper = attr[2:1];
  assign flags.vol  = attr[3];
  assign flags.enc  = attr[4];
  assign flags.priv = attr[5];
endmodule

// File: rtl/tw_walk_ctrl.sv
module tw_walk_ctrl
  import tw_pkg::*;
#(
  parameter int unsigned VA_W   = 49,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PA_W-1:0]     req_root,
  input  logic [VA_W-1:0]     req_va,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_fault,
  output logic [LVL_W-1:0]    rsp_level,
  output logic [PA_W-1:0]     rsp_pa,
  output leaf_flags_t         rsp_flags,
  // to the index selector
  output logic [VA_W-1:0]     va_cur,
  output logic [PA_W-1:0]     base_cur,
  output logic [LVL_W-1:0]    level_cur,
  input  logic [PA_W-1:0]     ent_addr,
  // to the entry decoder
  output logic [FIELD_W-1:0]  ent_field,
  output logic [ATTR_W-1:0]   ent_attr,
  output logic                last_lvl,
  input  ent_kind_e           ent_kind,
  input  logic [PA_W-1:0]     ent_next,
  input  leaf_flags_t         ent_flags
);
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISSUE = 3'd1,
    S_WAIT  = 3'd2,
    S_DEC   = 3'd3,
    S_RESP  = 3'd4
  } state_e;

  localparam int unsigned LAST = LEVELS - 1;

  state_e            state_q;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [DATA_W-1:0] ent_q;
  logic              fault_q;
  logic [LVL_W-1:0]  rlvl_q;
  logic [PA_W-1:0]   pa_q;
  leaf_flags_t       flags_q;

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = ent_addr;
  assign mem_rsp_ready = (state_q == S_WAIT);
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_level     = rlvl_q;
  assign rsp_pa        = pa_q;
  assign rsp_flags     = flags_q;

  assign va_cur    = va_q;
  assign base_cur  = base_q;
  assign level_cur = lvl_q;
  assign ent_field = ent_q[FIELD_LSB +: FIELD_W];
  assign ent_attr  = ent_q[ATTR_W-1:0];
  assign last_lvl  = (lvl_q == LVL_W'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      ent_q   <= '0;
      fault_q <= 1'b0;
      rlvl_q  <= '0;
      pa_q    <= '0;
      flags_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            base_q  <= req_root;
            lvl_q   <= '0;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            ent_q   <= mem_rsp_data;
            state_q <= S_DEC;
          end
        end
        S_DEC: begin
          case (ent_kind)
            ENT_BAD: begin
              fault_q <= 1'b1;
              rlvl_q  <= lvl_q;
              pa_q    <= '0;
              flags_q <= '0;
              state_q <= S_RESP;
            end
            ENT_LEAF: begin
              fault_q <= 1'b0;
              rlvl_q  <= lvl_q;
              pa_q    <= {ent_next[PA_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
              flags_q <= ent_flags;
              state_q <= S_RESP;
            end
            default: begin
              base_q  <= ent_next;
              lvl_q   <= lvl_q + LVL_W'(1);
              state_q <= S_ISSUE;
            end
          endcase
        end
        S_RESP: begin
          if (rsp_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: an accepted request closes the request port
  assert_busy_blocks_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R1: idle again right after the result is taken
  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);
  // R8: read request held under back-pressure
  assert_memreq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R8: never a new read while one is awaited
  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
  // R9: result held under back-pressure
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_fault, rsp_level, rsp_pa, rsp_flags})));
  // R5: reported level stays within the tree depth
  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_level <= LVL_W'(LAST)));
  // R10: the fetched word changes only when a read returns
  assert_entry_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_WAIT) |=> $stable(ent_q));
endmodule

// File: rtl/tree_walker.sv
module tree_walker
  import tw_pkg::*;
#(
  parameter int unsigned VA_W   = 49,
  parameter int unsigned PA_W   = 36,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_root,
  input  logic [VA_W-1:0]   req_va,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [2:0]        rsp_level,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_aperture,
  output logic              rsp_volatile,
  output logic              rsp_encrypted,
  output logic              rsp_privileged
);
  logic [VA_W-1:0]    va_cur;
  logic [PA_W-1:0]    base_cur;
  logic [LVL_W-1:0]   level_cur;
  logic [PA_W-1:0]    ent_addr;
  logic [FIELD_W-1:0] ent_field;
  logic [ATTR_W-1:0]  ent_attr;
  logic               last_lvl;
  ent_kind_e          ent_kind;
  logic [PA_W-1:0]    ent_next;
  leaf_flags_t        ent_flags;
  leaf_flags_t        rsp_flags;

  tw_walk_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_root      (req_root),
    .req_va        (req_va),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_level     (rsp_level),
    .rsp_pa        (rsp_pa),
    .rsp_flags     (rsp_flags),
    .va_cur        (va_cur),
    .base_cur      (base_cur),
    .level_cur     (level_cur),
    .ent_addr      (ent_addr),
    .ent_field     (ent_field),
    .ent_attr      (ent_attr),
    .last_lvl      (last_lvl),
    .ent_kind      (ent_kind),
    .ent_next      (ent_next),
    .ent_flags     (ent_flags)
  );

  tw_index_sel #(.VA_W(VA_W), .PA_W(PA_W)) u_index (
    .vpn      (va_cur[VA_W-1:PAGE_SHIFT]),
    .base     (base_cur),
    .level    (level_cur),
    .ent_addr (ent_addr)
  );

  tw_entry_decode #(.PA_W(PA_W)) u_decode (
    .addr_field (ent_field),
    .attr       (ent_attr),
    .last_lvl   (last_lvl),
    .kind       (ent_kind),
    .next_base  (ent_next),
    .flags      (ent_flags)
  );

  assign rsp_aperture   = rsp_flags.aper;
  assign rsp_volatile   = rsp_flags.vol;
  assign rsp_encrypted  = rsp_flags.enc;
  assign rsp_privileged = rsp_flags.priv;
endmodule

// File: tb/tree_walker_bench.sv
module tree_walker_bench;
  localparam int VA_W = 49;
  localparam int PA_W = 36;
  localparam int DW   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req_valid, req_ready;
  logic [PA_W-1:0] req_root;
  logic [VA_W-1:0] req_va;
  logic            mem_req_valid, mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid, mem_rsp_ready;
  logic [DW-1:0]   mem_rsp_data;
  logic            rsp_valid, rsp_ready, rsp_fault;
  logic [2:0]      rsp_level;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0]      rsp_aperture;
  logic            rsp_volatile, rsp_encrypted, rsp_privileged;

  tree_walker u_tree_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_root(req_root), .req_va(req_va),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_pa(rsp_pa), .rsp_aperture(rsp_aperture), .rsp_volatile(rsp_volatile),
    .rsp_encrypted(rsp_encrypted), .rsp_privileged(rsp_privileged)
  );

  logic [63:0]      memory [longint unsigned];
  longint unsigned  exp_addrs [$];
  logic [PA_W-1:0]  vec_root [$];
  logic [VA_W-1:0]  vec_va [$];
  bit               exp_fault;
  int               exp_level;
  logic [PA_W-1:0]  exp_pa;
  logic [4:0]       exp_flags;
  int               n_chk = 0;
  int               n_err = 0;
  int unsigned      next_tbl = 32'h100;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int lsb_of(int l);
    case (l) 0: return 47; 1: return 38; 2: return 29; 3: return 21; default: return 12; endcase
  endfunction
  function automatic int wid_of(int l);
    case (l) 0: return 2; 3: return 8; default: return 9; endcase
  endfunction
  function automatic longint unsigned slot(longint unsigned base, logic [VA_W-1:0] va, int l);
    longint unsigned idx;
    idx = (64'(va) >> lsb_of(l)) & ((64'd1 << wid_of(l)) - 64'd1);
    return base + idx * ((l == 3) ? 64'd16 : 64'd8);
  endfunction
  function automatic logic [63:0] rd(longint unsigned a);
    if (memory.exists(a)) return memory[a];
    return 64'd0;
  endfunction

  // kind 0 = invalid target, 1 = leaf bit, 2 = level-4 entry without leaf bit
  task automatic build(input logic [VA_W-1:0] va, input int stop, input int kind, input logic [4:0] fl);
    longint unsigned base;
    logic [23:0] f;
    logic [5:0]  low;
    base = {next_tbl[23:0], 12'h000};
    vec_root.push_back(base[PA_W-1:0]);
    vec_va.push_back(va);
    next_tbl++;
    for (int l = 0; l < stop; l++) begin
      f = next_tbl[23:0];
      next_tbl++;
      memory[slot(base, va, l)] = {$urandom(), f, 2'b11, 3'($urandom()), 3'b010};
      base = {f, 12'h000};
    end
    f = 24'($urandom());
    case (kind)
      0:       low = {3'($urandom()), 3'b000};
      1:       low = {fl[0], fl[1], fl[2], fl[4:3], 1'b1};
      default: low = {fl[0], fl[1], fl[2], fl[4:3] | 2'b10, 1'b0};
    endcase
    memory[slot(base, va, stop)] = {$urandom(), f, 2'($urandom()), low};
  endtask

  task automatic model_walk(input logic [PA_W-1:0] root, input logic [VA_W-1:0] va);
    longint unsigned base, a;
    logic [63:0] e;
    exp_addrs.delete();
    base = 64'(root);
    for (int l = 0; l < 5; l++) begin
      a = slot(base, va, l);
      exp_addrs.push_back(a);
      e = rd(a);
      if (e[2:0] == 3'b000) begin
        exp_fault = 1'b1; exp_level = l; exp_pa = '0; exp_flags = '0;
        return;
      end
      if (e[0] || l == 4) begin
        exp_fault = 1'b0; exp_level = l;
        exp_pa = {e[31:8], va[11:0]};
        exp_flags = {e[2:1], e[3], e[4], e[5]};
        return;
      end
      base = {28'd0, e[31:8], 12'h000};
    end
  endtask

  initial begin
    int  vi = 0;
    int  gap = 0;
    int  cyc = 0;
    int  rd_lvl = 0;
    bit  busy = 0;
    bit  done = 0;
    bit  pend_v = 0;
    int  pend_cnt = 0;
    logic [63:0] pend_d = '0;
    bit  mem_stall = 0;
    bit  rsp_stall = 0;
    logic [PA_W-1:0] saved_maddr = '0;
    logic [44:0] saved_rsp = '0;
    longint unsigned a;

    req_valid = 0; req_root = '0; req_va = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0; rsp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req_ready", 64'(req_ready), 1);
    chk("R1 reset rsp_valid", 64'(rsp_valid), 0);
    chk("R1 reset mem_req_valid", 64'(mem_req_valid), 0);

    // directed walks
    build(49'h0_1234_5678_9ABC, 4, 1, 5'b01101);   // full walk, leaf flags (R7)
    build(49'h1_8000_0000_0123, 0, 0, 5'b0);        // fault at level 0 (R5)
    build(49'h0_0000_1FE0_0FFF, 3, 0, 5'b0);        // fault at level 3, top index (R3)
    build(49'h0_5555_5555_5555, 4, 0, 5'b0);        // fault at level 4
    build(49'h0_2468_ACE1_3579, 2, 1, 5'b10010);    // early leaf at level 2 (R6)
    build(49'h0_0F0F_0F0F_0F0F, 4, 2, 5'b11011);    // level 4 without leaf bit (R6)
    build(49'h1_FFFF_FFFF_FFFF, 4, 1, 5'b11111);    // all-ones address
    build(49'h0_0000_0000_0000, 0, 1, 5'b00100);    // leaf at level 0
    build(49'h0_7777_1357_2468, 1, 0, 5'b0);        // fault at level 1
    build(49'h1_3333_4444_5555, 2, 0, 5'b0);        // fault at level 2
    build(49'h0_1111_00E0_0ABC, 3, 1, 5'b01010);    // leaf at level 3, odd index (R3)
    for (int k = 0; k < 12; k++) begin
      int st;
      int kd;
      st = $urandom_range(4);
      kd = (st == 4) ? $urandom_range(2) : $urandom_range(1);
      build({$urandom(), 17'($urandom())}, st, kd, 5'($urandom()));
    end

    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_err++;
        $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 100000", cyc);
        break;
      end
      // per-cycle comparison against the model
      chk("R1 req_ready vs model", 64'(req_ready), 64'(!busy));
      if (mem_stall) begin
        chk("R8 mem_req_valid held", 64'(mem_req_valid), 1);
        chk("R8 mem_req_addr held", 64'(mem_req_addr), 64'(saved_maddr));
      end
      if (rsp_stall) begin
        chk("R9 rsp_valid held", 64'(rsp_valid), 1);
        chk("R9 rsp fields held", 64'({rsp_fault, rsp_level, rsp_pa, rsp_aperture,
            rsp_volatile, rsp_encrypted, rsp_privileged}), 64'(saved_rsp));
      end

      // drive inputs
      if (!busy && vi < vec_root.size()) begin
        if (gap == 0) begin
          req_valid = 1; req_root = vec_root[vi]; req_va = vec_va[vi];
        end else begin
          req_valid = 0; gap--;
        end
      end else req_valid = 0;
      mem_req_ready = ($urandom_range(3) != 0);
      if (pend_v && pend_cnt == 0) begin
        mem_rsp_valid = 1; mem_rsp_data = pend_d;
      end else begin
        mem_rsp_valid = 0; mem_rsp_data = {$urandom(), $urandom()};
        if (pend_v) pend_cnt--;
      end
      rsp_ready = ($urandom_range(2) != 0);

      // handshakes that the coming edge completes
      if (req_valid && req_ready) begin
        model_walk(req_root, req_va);
        busy = 1; vi++; rd_lvl = 0; gap = $urandom_range(2);
      end
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addrs.size() == 0) chk("R5 read after walk end", 1, 0);
        else begin
          a = exp_addrs.pop_front();
          chk(rd_lvl == 3 ? "R3 entry stride" : "R2 entry index", 64'(mem_req_addr), a);
        end
        rd_lvl++;
        pend_d = rd(64'(mem_req_addr)); pend_v = 1; pend_cnt = $urandom_range(2);
      end
      if (mem_rsp_valid && mem_rsp_ready) pend_v = 0;
      mem_stall = mem_req_valid && !mem_req_ready;
      saved_maddr = mem_req_addr;
      rsp_stall = rsp_valid && !rsp_ready;
      saved_rsp = {rsp_fault, rsp_level, rsp_pa, rsp_aperture, rsp_volatile, rsp_encrypted, rsp_privileged};
      if (rsp_valid && rsp_ready) begin
        chk(exp_fault ? "R5 fault" : "R6 fault", 64'(rsp_fault), 64'(exp_fault));
        chk(exp_fault ? "R5 level" : "R6 level", 64'(rsp_level), 64'(exp_level));
        chk("R4 physical address", 64'(rsp_pa), 64'(exp_pa));
        chk("R7 leaf flags", 64'({rsp_aperture, rsp_volatile, rsp_encrypted, rsp_privileged}), 64'(exp_flags));
        chk("R10 read count", 64'(exp_addrs.size()), 0);
        busy = 0;
        if (vi == vec_root.size()) done = 1;
      end
    end
    @(negedge clk);
    chk("R1 ready after last walk", 64'(req_ready), 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule